// File: doc/BRIEF.md
# DMA Bus Strobe Sequencer

This block paces DMA word transfers on a 16-bit peripheral bus. Once started, it drives an active-low read strobe (device to memory) or an active-low write strobe (memory to device) once per word. It emits a transfer tick in the cycle each word completes and raises a one-cycle done flag after the final word. A 4-bit period code sets how many cycles the strobe stays low for each word, and the strobe goes high for a single cycle between words. The all-ones code instead holds the strobe low for the whole burst and moves one word per cycle.

A select input picks the period code from either the DMA timing field or the programmed-I/O timing field, and the same rules apply to both. In wide mode each transfer carries 32 bits. The low half travels on the data lines and the high half on the low address lines. On transfers toward memory the block leaves the address lines undriven so that they act as inputs. Address generation, arbitration and the memory side belong to the surrounding logic.

Top module: `dma_strobe_seq`

## Requirements
- R1: For a period code c from 2 to 14, and for code 0 on writes, each word's strobe stays low for exactly c+1 cycles.
- R2: Between two consecutive words of one burst with a code other than 15, both strobes are high for exactly one cycle.
- R3: With code 15, the strobe stays low for exactly N consecutive cycles for N words, and the transfer tick is high in every one of those cycles.
- R4: On reads, codes 0 and 1 both give a two-cycle low period. On writes, code 1 gives two cycles.
- R5: `to_mem`=1 selects the read strobe and `to_mem`=0 selects the write strobe. The other strobe stays high for the whole burst.
- R6: The transfer tick fires only in the last low cycle of each word, once per word. On reads, `rd_word` takes the bus value sampled at the clock edge that ends that cycle.
- R7: In wide mode a read captures `{bus_addr_in, bus_data_in}`, while a narrow read captures `{16'h0, bus_data_in}`. A wide write drives `wr_word[31:16]` on `bus_addr_out` with `bus_addr_oe`=1 while the strobe is low. `bus_addr_oe` is never 1 on a read.
- R8: On writes, `bus_data_oe`=1 and `bus_data_out`=`wr_word[15:0]` during every low cycle. On reads, `bus_data_oe` stays 0.
- R9: `use_pio`=1 takes the period code from `pio_code`. `use_pio`=0 takes it from `dma_code`.
- R10: `done` is high for exactly one cycle, in the cycle right after the final low period. Both strobes are high in that cycle, and `busy` is 0 in the cycle after it.
- R11: A start while `busy`=1 (including the done cycle) has no effect on the running burst, and a start with `word_count`=0 is ignored.
- R12: After reset, both strobes are high and `busy`, `done`, `xfer_tick` and both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst (sampled when idle) |
| to_mem | input | 1 | 1 = read from device toward memory, 0 = write to device |
| wide_mode | input | 1 | 32-bit transfers using the address lines for the upper half |
| use_pio | input | 1 | Timing source select: 1 = pio_code, 0 = dma_code |
| dma_code | input | 4 | DMA period code |
| pio_code | input | 4 | Programmed-I/O period code |
| word_count | input | CNT_W | Number of words in the burst |
| wr_word | input | 32 | Word to be written |
| bus_data_in | input | 16 | Data lines, input side |
| bus_addr_in | input | 16 | Low address lines, input side |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| bus_data_out | output | 16 | Data lines, output side |
| bus_data_oe | output | 1 | Data line output enable |
| bus_addr_out | output | 16 | Low address lines, output side (upper half of a wide word) |
| bus_addr_oe | output | 1 | Address line output enable for wide writes |
| rd_word | output | 32 | Last word captured on a read |
| xfer_tick | output | 1 | One word completes this cycle |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst flag |

## Verification
The hardest conditions to reach from the ports are a start arriving in the middle of a burst and a start landing exactly in the done cycle. In both cases the block must ignore the request, and the only visible proof is that the word and tick counts stay as they were. The stimulus raises start at a fixed cycle inside a running burst with a different word count, and raises it again in the cycle where done is observed. The per-word tally must still match the original burst, and the block must return to idle. Code 15 with a single word and code 14 at the slowest period are also driven, because they sit at the boundaries of the length rules.

// File: rtl/dss_pkg.sv
`timescale 1ns/1ps
package dss_pkg;
    localparam int CODE_W = 4;
    localparam int LEN_W  = 4;
    localparam logic [CODE_W-1:0] CODE_BURST = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_GAP,
        ST_RUN,
        ST_FIN
    } seq_state_t;

    typedef enum logic {
        DIR_TO_DEV = 1'b0,
        DIR_TO_MEM = 1'b1
    } xfer_dir_t;

    typedef struct packed {
        logic             burst;
        logic [LEN_W-1:0] low_len;
    } period_t;

    typedef struct packed {
        xfer_dir_t dir;
        logic      wide;
        period_t   per;
    } job_t;

    // Strobe-low length for one word, from code and direction.
    function automatic period_t decode_period(logic [CODE_W-1:0] code, xfer_dir_t dir);
        period_t p;
        p.burst   = (code == CODE_BURST);
        p.low_len = code + LEN_W'(1);
        if (p.burst)
            p.low_len = LEN_W'(1);
        else if (code == '0 && dir == DIR_TO_MEM)
            p.low_len = LEN_W'(2);
        return p;
    endfunction
endpackage

// File: rtl/dss_period_sel.sv
`timescale 1ns/1ps
module dss_period_sel
    import dss_pkg::*;
(
    input  logic              use_pio,
    input  logic [CODE_W-1:0] dma_code,
    input  logic [CODE_W-1:0] pio_code,
    input  xfer_dir_t         dir,
    output period_t           per
);
    logic [CODE_W-1:0] code_sel;

    always_comb begin
        code_sel = use_pio ? pio_code : dma_code;
        per      = decode_period(code_sel, dir);
    end

    always_comb begin
        a_r4_read_floor_imm: assert (per.burst || dir != DIR_TO_MEM || per.low_len >= LEN_W'(2));
    end
endmodule

// File: rtl/dss_ctrl.sv
`timescale 1ns/1ps
module dss_ctrl
    import dss_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] word_count,
    input  xfer_dir_t        dir_in,
    input  logic             wide_in,
    input  period_t          per_in,
    output job_t             job,
    output logic             strobe_low,
    output logic             tick,
    output logic             busy,
    output logic             done
);
    seq_state_t        state;
    logic [LEN_W-1:0]  cnt;
    logic [CNT_W-1:0]  left;
    logic              last_low;

    always_comb begin
        last_low   = (state == ST_LOW) && (cnt == job.per.low_len - LEN_W'(1));
        strobe_low = (state == ST_LOW) || (state == ST_RUN);
        tick       = last_low || (state == ST_RUN);
        busy       = (state != ST_IDLE);
        done       = (state == ST_FIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            left  <= '0;
            job   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start && word_count != '0) begin
                        job.dir  <= dir_in;
                        job.wide <= wide_in;
                        job.per  <= per_in;
                        left     <= word_count;
                        cnt      <= '0;
                        state    <= per_in.burst ? ST_RUN : ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (last_low) begin
                        cnt   <= '0;
                        left  <= left - CNT_W'(1);
                        state <= (left == CNT_W'(1)) ? ST_FIN : ST_GAP;
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                ST_GAP: state <= ST_LOW;
                ST_RUN: begin
                    left <= left - CNT_W'(1);
                    if (left == CNT_W'(1))
                        state <= ST_FIN;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r2_gap_single: assert property (@(posedge clk) disable iff (rst)
        state == ST_GAP |=> state == ST_LOW);
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);
    a_r6_tick_in_low: assert property (@(posedge clk) disable iff (rst)
        tick |-> strobe_low);
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !tick) |=> $stable(left) && $stable(job));
    a_r1_len_bound: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOW |-> cnt < job.per.low_len);
    a_r3_run_tick: assert property (@(posedge clk) disable iff (rst)
        state == ST_RUN |-> tick && job.per.burst);
endmodule

// File: rtl/dss_lane.sv
`timescale 1ns/1ps
module dss_lane
    import dss_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_low,
    input  logic              tick,
    input  job_t              job,
    input  logic [2*HALF_W-1:0] wr_word,
    input  logic [HALF_W-1:0] bus_data_in,
    input  logic [HALF_W-1:0] bus_addr_in,
    output logic [HALF_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic [HALF_W-1:0] bus_addr_out,
    output logic              bus_addr_oe,
    output logic [2*HALF_W-1:0] rd_word
);
    always_comb begin
        bus_data_oe  = strobe_low && job.dir == DIR_TO_DEV;
        bus_addr_oe  = bus_data_oe && job.wide;
        bus_data_out = bus_data_oe ? wr_word[HALF_W-1:0] : '0;
        bus_addr_out = bus_addr_oe ? wr_word[2*HALF_W-1:HALF_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_word <= '0;
        else if (tick && job.dir == DIR_TO_MEM)
            rd_word <= job.wide ? {bus_addr_in, bus_data_in} : {{HALF_W{1'b0}}, bus_data_in};
    end

    a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        job.dir == DIR_TO_MEM |-> !bus_data_oe && !bus_addr_oe);
    a_r7_capture_width: assert property (@(posedge clk) disable iff (rst)
        (tick && job.dir == DIR_TO_MEM && !job.wide) |=> rd_word[2*HALF_W-1:HALF_W] == '0);
endmodule

// File: rtl/dma_strobe_seq.sv
`timescale 1ns/1ps
module dma_strobe_seq
    import dss_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                to_mem,
    input  logic                wide_mode,
    input  logic                use_pio,
    input  logic [3:0]          dma_code,
    input  logic [3:0]          pio_code,
    input  logic [CNT_W-1:0]    word_count,
    input  logic [2*HALF_W-1:0] wr_word,
    input  logic [HALF_W-1:0]   bus_data_in,
    input  logic [HALF_W-1:0]   bus_addr_in,
    output logic                rd_strobe_n,
    output logic                wr_strobe_n,
    output logic [HALF_W-1:0]   bus_data_out,
    output logic                bus_data_oe,
    output logic [HALF_W-1:0]   bus_addr_out,
    output logic                bus_addr_oe,
    output logic [2*HALF_W-1:0] rd_word,
    output logic                xfer_tick,
    output logic                busy,
    output logic                done
);
    xfer_dir_t dir_in;
    period_t   per_in;
    job_t      job;
    logic      strobe_low;

    assign dir_in = to_mem ? DIR_TO_MEM : DIR_TO_DEV;

    dss_period_sel u_sel (
        .use_pio  (use_pio),
        .dma_code (dma_code),
        .pio_code (pio_code),
        .dir      (dir_in),
        .per      (per_in)
    );

    dss_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .word_count (word_count),
        .dir_in     (dir_in),
        .wide_in    (wide_mode),
        .per_in     (per_in),
        .job        (job),
        .strobe_low (strobe_low),
        .tick       (xfer_tick),
        .busy       (busy),
        .done       (done)
    );

    dss_lane #(.HALF_W(HALF_W)) u_lane (
        .clk          (clk),
        .rst          (rst),
        .strobe_low   (strobe_low),
        .tick         (xfer_tick),
        .job          (job),
        .wr_word      (wr_word),
        .bus_data_in  (bus_data_in),
        .bus_addr_in  (bus_addr_in),
        .bus_data_out (bus_data_out),
        .bus_data_oe  (bus_data_oe),
        .bus_addr_out (bus_addr_out),
        .bus_addr_oe  (bus_addr_oe),
        .rd_word      (rd_word)
    );

    assign rd_strobe_n = !(strobe_low && job.dir == DIR_TO_MEM);
    assign wr_strobe_n = !(strobe_low && job.dir == DIR_TO_DEV);

    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({~rd_strobe_n, ~wr_strobe_n}));
    a_r10_done_strobes_high: assert property (@(posedge clk) disable iff (rst)
        done |-> rd_strobe_n && wr_strobe_n);
endmodule

// File: tb/dma_strobe_seq_bench.sv
`timescale 1ns/1ps
module dma_strobe_seq_bench;
    logic        clk = 0;
    logic        rst, start, to_mem, wide_mode, use_pio;
    logic [3:0]  dma_code, pio_code;
    logic [7:0]  word_count;
    logic [31:0] wr_word;
    logic [15:0] bus_data_in, bus_addr_in;
    logic        rd_strobe_n, wr_strobe_n, bus_data_oe, bus_addr_oe, xfer_tick, busy, done;
    logic [15:0] bus_data_out, bus_addr_out;
    logic [31:0] rd_word;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    dma_strobe_seq u_dma_strobe_seq (
        .clk(clk), .rst(rst), .start(start), .to_mem(to_mem), .wide_mode(wide_mode),
        .use_pio(use_pio), .dma_code(dma_code), .pio_code(pio_code), .word_count(word_count),
        .wr_word(wr_word), .bus_data_in(bus_data_in), .bus_addr_in(bus_addr_in),
        .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n), .bus_data_out(bus_data_out),
        .bus_data_oe(bus_data_oe), .bus_addr_out(bus_addr_out), .bus_addr_oe(bus_addr_oe),
        .rd_word(rd_word), .xfer_tick(xfer_tick), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d exp=<100000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Expected low length per word, straight from R1/R3/R4.
    function automatic int exp_len(input logic [3:0] code, input logic rd, input int n);
        if (code == 4'hF) return n;
        if (rd && code <= 1) return 2;
        return int'(code) + 1;
    endfunction

    // {to_mem, code[3:0], words[3:0], wide}
    localparam logic [9:0] VEC [10] = '{
        {1'b0, 4'd0,  4'd3, 1'b0},
        {1'b1, 4'd0,  4'd3, 1'b0},
        {1'b0, 4'd1,  4'd2, 1'b1},
        {1'b1, 4'd1,  4'd2, 1'b1},
        {1'b1, 4'd2,  4'd1, 1'b0},
        {1'b0, 4'd5,  4'd4, 1'b1},
        {1'b1, 4'd14, 4'd2, 1'b1},
        {1'b0, 4'd14, 4'd1, 1'b0},
        {1'b1, 4'd15, 4'd5, 1'b1},
        {1'b0, 4'd15, 4'd1, 1'b0}
    };

    task automatic run(input logic rd, input logic [3:0] dcode, input int n, input logic wd,
                       input logic sel_pio, input logic [3:0] pcode,
                       input bit inj_mid, input bit inj_done);
        logic [3:0] code;
        int len, runlen, gaplen, runs, bad_len, bad_gap, ticks, bad_tick;
        int bad_strobe, bad_oe, done_cnt, bad_done;
        bit burst;
        logic [31:0] exp_rd;
        code  = sel_pio ? pcode : dcode;
        burst = (code == 4'hF);
        len   = exp_len(code, rd, n);
        runlen = 0; gaplen = 0; runs = 0; bad_len = 0; bad_gap = 0; ticks = 0; bad_tick = 0;
        bad_strobe = 0; bad_oe = 0; done_cnt = 0; bad_done = 0;
        @(negedge clk);
        to_mem = rd; dma_code = dcode; pio_code = pcode; use_pio = sel_pio;
        word_count = 8'(n); wide_mode = wd;
        wr_word = {8'h5A, 4'(n), code, 8'hC3, 4'(n), code};
        bus_data_in = {4'hA, code, 4'(n), 4'h6};
        bus_addr_in = ~{4'hA, code, 4'(n), 4'h6};
        exp_rd = wd ? {bus_addr_in, bus_data_in} : {16'h0, bus_data_in};
        start = 1;
        @(negedge clk);
        start = 0;
        for (int it = 0; it < 400; it++) begin
            logic low;
            low = !rd_strobe_n || !wr_strobe_n;
            if (inj_mid && it == 2) begin start = 1; word_count = 8'd7; to_mem = !rd; end
            if (inj_mid && it == 3) start = 0;
            if (low) begin
                if (rd ? !wr_strobe_n : !rd_strobe_n) bad_strobe++;
                if (runlen == 0 && runs > 0 && gaplen != 1) bad_gap++;
                gaplen = 0;
                runlen++;
                if (!rd && (!bus_data_oe || bus_data_out != wr_word[15:0] || bus_addr_oe != wd ||
                            (wd && bus_addr_out != wr_word[31:16]))) bad_oe++;
                if (rd && (bus_data_oe || bus_addr_oe)) bad_oe++;
                if (burst && !xfer_tick) bad_tick++;
                if (xfer_tick) begin
                    ticks++;
                    if (!burst && runlen != len) bad_tick++;
                end
                if (done) bad_done++;
            end else begin
                if (xfer_tick) bad_tick++;
                if (runlen > 0) begin
                    runs++;
                    if (runlen != len) bad_len++;
                end
                runlen = 0;
                if (done) begin
                    done_cnt++;
                    break;
                end
                gaplen++;
            end
            @(negedge clk);
        end
        chk(bad_len == 0, burst ? "R3" : (code <= 1 ? "R4" : "R1"), "low-period length mismatches", bad_len, 0);
        chk(runs == (burst ? 1 : n), burst ? "R3" : "R2", "low periods", runs, burst ? 1 : n);
        if (!burst) chk(bad_gap == 0, "R2", "gap not one cycle", bad_gap, 0);
        chk(ticks == n && bad_tick == 0, "R6", "ticks (bad placements)", ticks * 256 + bad_tick, n * 256);
        chk(bad_strobe == 0, "R5", "wrong strobe low", bad_strobe, 0);
        chk(bad_oe == 0, rd ? "R8" : "R7", "bus drive errors", bad_oe, 0);
        chk(done_cnt == 1 && bad_done == 0, "R10", "done in cycle after final word", done_cnt, 1);
        if (inj_done) start = 1;
        @(negedge clk);
        start = 0;
        chk(!done && !busy, inj_done ? "R11" : "R10", "idle after done (done,busy)", {done, busy}, 0);
        chk(rd_strobe_n && wr_strobe_n, inj_done ? "R11" : "R10", "strobes high after done",
            {rd_strobe_n, wr_strobe_n}, 3);
        if (rd) chk(rd_word == exp_rd, "R7", "captured read word", rd_word, exp_rd);
    endtask

    initial begin
        rst = 1; start = 0; to_mem = 0; wide_mode = 0; use_pio = 0;
        dma_code = 0; pio_code = 0; word_count = 0; wr_word = 0;
        bus_data_in = 0; bus_addr_in = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        chk(rd_strobe_n && wr_strobe_n && !busy && !done && !xfer_tick && !bus_data_oe && !bus_addr_oe,
            "R12", "reset outputs", {rd_strobe_n, wr_strobe_n, busy, done, xfer_tick, bus_data_oe, bus_addr_oe},
            7'b1100000);

        // Table walk: R1..R8, R10
        foreach (VEC[i]) begin
            run(VEC[i][9], VEC[i][8:5], int'(VEC[i][4:1]), VEC[i][0], 1'b0, 4'd0, 1'b0, 1'b0);
        end

        // R9: pio source selected (dma code would be burst)
        run(1'b1, 4'd15, 3, 1'b0, 1'b1, 4'd3, 1'b0, 1'b0);
        // R9: dma source selected while pio code differs
        run(1'b0, 4'd2, 2, 1'b1, 1'b0, 4'd9, 1'b0, 1'b0);
        // R11: start mid-burst and in the done cycle
        run(1'b1, 4'd3, 3, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1);
        run(1'b0, 4'd15, 4, 1'b0, 1'b0, 4'd0, 1'b1, 1'b1);

        // R11: zero word count ignored
        @(negedge clk);
        word_count = 0; dma_code = 4'd2; use_pio = 0; start = 1;
        @(negedge clk);
        start = 0;
        for (int k = 0; k < 4; k++) begin
            chk(!busy && rd_strobe_n && wr_strobe_n && !done, "R11", "zero-count start ignored",
                {busy, rd_strobe_n, wr_strobe_n, done}, 4'b0110);
            @(negedge clk);
        end

        // R12: reset in the middle of a burst
        word_count = 8'd4; dma_code = 4'd6; to_mem = 0; start = 1;
        @(negedge clk);
        start = 0;
        @(negedge clk);
        chk(!wr_strobe_n && busy, "R1", "burst running before reset", {wr_strobe_n, busy}, 2'b01);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk(rd_strobe_n && wr_strobe_n && !busy && !bus_data_oe, "R12", "reset mid-burst",
            {rd_strobe_n, wr_strobe_n, busy, bus_data_oe}, 4'b1100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule